// File: doc/BRIEF.md
# Toggle-Signalled Event Crossing

This block carries single events, each with a data word, from a source clock domain to a destination clock domain whose clock has no known relation to the source clock. The source side marks a new event by inverting a request line, and it leaves that line at the new level. The destination side synchronizes the line into its own clock. It finds the inversion by comparing the synchronized value with the value it registered one cycle earlier. It then emits a one-cycle valid pulse with the captured word and inverts an acknowledge line that returns to the source.

The source synchronizes the acknowledge line and finds its inversion in the same way. It then drops its busy flag and can take the next event. Each transfer has only a request phase and an acknowledge phase. Neither line ever has to return to a resting level, so a round trip costs about half the cycles of a four-phase exchange. Both domains use asynchronous active-low resets.

A producer drives `src_send` with a word for one cycle while `src_busy` is low. A consumer samples `dst_data` on the cycle `dst_valid` is high.

Top module: `toggle_event_xfer`

## Requirements
- R1: While reset is asserted, `src_busy`, `dst_valid` and `dst_data` are all 0.
- R2: A cycle with `src_send` high while `src_busy` is low accepts the event. `src_busy` is high from the next source clock edge onward.
- R3: `src_send` is ignored while `src_busy` is high. It produces no additional destination event and does not change the word in flight.
- R4: Each accepted event produces exactly one `dst_valid` pulse, and that pulse lasts exactly one destination cycle.
- R5: Events arrive in the order they were accepted. `dst_data` during the pulse equals the `src_data` sampled in the accepting cycle.
- R6: `src_busy` falls only after the acknowledge inversion has crossed back, which takes at least 3 source cycles. It falls within a bounded time, after which a new event can be accepted.
- R7: Both directions of inversion (0 to 1 and 1 to 0) on each crossing line count as an event, so consecutive events are all delivered.
- R8: `dst_data` holds its last delivered value on every cycle in which `dst_valid` is low.
- R9: The word in flight stays stable in the source domain for as long as `src_busy` is high, even if `src_data` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_send | input | 1 | Request to send one event |
| src_data | input | DATA_W | Word that goes with the event |
| src_busy | output | 1 | An event is in flight, so new sends are ignored |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle pulse per delivered event |
| dst_data | output | DATA_W | Delivered word, held between pulses |

## Verification
The bench builds the block with its defaults: an 8-bit word and two synchronizer stages on each crossing line. The source clock runs at 20 ns and the destination clock at 33 ns. With these settings the bench can reach long runs of events in which the request and acknowledge lines flip in both directions. It can also reach send attempts and data changes landing in the middle of a round trip, and the resulting busy windows are short enough for each one to be timed against its bound.

// File: rtl/tgx_pkg.sv
package tgx_pkg;

    // Smallest synchronizer depth accepted on a crossing line
    localparam int unsigned TGX_MIN_STAGES = 2;

    // Source side: idle, or waiting for the acknowledge inversion
    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_WAIT = 1'b1
    } src_phase_e;

endpackage

// File: rtl/tgx_sync.sv
module tgx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    import tgx_pkg::*;

    localparam int unsigned DEPTH = (STAGES < TGX_MIN_STAGES) ? TGX_MIN_STAGES : STAGES;

    logic [DEPTH-1:0] chain_d;
    logic [DEPTH-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[DEPTH-1];

endmodule

// File: rtl/tgx_src.sv
module tgx_src #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ack_sync_i,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o
);
    import tgx_pkg::*;

    typedef struct packed {
        src_phase_e        phase;
        logic              req;
        logic              ack_prev;
        logic [DATA_W-1:0] data;
    } src_state_t;

    src_state_t state_d, state_q;
    logic       ack_flip;

    always_comb begin
        state_d          = state_q;
        state_d.ack_prev = ack_sync_i;
        ack_flip         = ack_sync_i ^ state_q.ack_prev;
        case (state_q.phase)
            SRC_IDLE: begin
                if (send_i) begin
                    state_d.req   = ~state_q.req;
                    state_d.data  = data_i;
                    state_d.phase = SRC_WAIT;
                end
            end
            default: begin
                if (ack_flip) state_d.phase = SRC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_o  = state_q.req;
    assign data_o = state_q.data;
    assign busy_o = (state_q.phase == SRC_WAIT);

    // R2: an idle send flips the request and enters the wait phase
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.phase == SRC_IDLE && send_i) |=>
            (state_q.phase == SRC_WAIT && state_q.req != $past(state_q.req)));

    // R3: no request flip may follow a busy cycle
    assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.phase == SRC_WAIT) |=> (state_q.req == $past(state_q.req)));

    // R9: the word in flight is frozen while waiting
    assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.phase == SRC_WAIT) |=> $stable(state_q.data));

endmodule

// File: rtl/tgx_dst.sv
module tgx_dst #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              req_prev;
        logic              ack;
        logic              valid;
        logic [DATA_W-1:0] data;
    } dst_state_t;

    dst_state_t state_d, state_q;
    logic       req_flip;

    always_comb begin
        state_d          = state_q;
        state_d.req_prev = req_sync_i;
        state_d.valid    = 1'b0;
        req_flip         = req_sync_i ^ state_q.req_prev;
        if (req_flip) begin
            state_d.valid = 1'b1;
            state_d.data  = data_i;
            state_d.ack   = ~state_q.ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ack_o   = state_q.ack;
    assign valid_o = state_q.valid;
    assign data_o  = state_q.data;

    // R4: a pulse is never two cycles wide
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.valid |=> !state_q.valid);

    // R6: the acknowledge flips only together with a delivery
    assert_ack_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ack != $past(state_q.ack)) |-> state_q.valid);

    // R8: the output word only moves on a delivery
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.valid |-> $stable(state_q.data));

endmodule

// File: rtl/toggle_event_xfer.sv
module toggle_event_xfer #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_send,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);
    logic              req_line;
    logic              req_in_dst;
    logic              ack_line;
    logic              ack_in_src;
    logic [DATA_W-1:0] held_word;

    tgx_src #(.DATA_W(DATA_W)) u_src (
        .clk        (src_clk),
        .rst_n      (src_rst_n),
        .send_i     (src_send),
        .data_i     (src_data),
        .ack_sync_i (ack_in_src),
        .req_o      (req_line),
        .data_o     (held_word),
        .busy_o     (src_busy)
    );

    tgx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d_i   (req_line),
        .q_o   (req_in_dst)
    );

    tgx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d_i   (ack_line),
        .q_o   (ack_in_src)
    );

    tgx_dst #(.DATA_W(DATA_W)) u_dst (
        .clk        (dst_clk),
        .rst_n      (dst_rst_n),
        .req_sync_i (req_in_dst),
        .data_i     (held_word),
        .ack_o      (ack_line),
        .valid_o    (dst_valid),
        .data_o     (dst_data)
    );

endmodule

// File: tb/tb_toggle_event_xfer.sv
module tb_toggle_event_xfer;
    localparam int DATA_W = 8;

    logic              src_clk = 1'b0;
    logic              dst_clk = 1'b0;
    logic              src_rst_n = 1'b0;
    logic              dst_rst_n = 1'b0;
    logic              src_send = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_busy;
    logic              dst_valid;
    logic [DATA_W-1:0] dst_data;

    int n_checks = 0;
    int n_fail   = 0;
    int accepted = 0;
    int delivered = 0;
    bit run_on   = 1'b0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] last_word = '0;
    logic              prev_valid = 1'b0;

    always #10 src_clk = ~src_clk;   // 50 MHz source
    always #16.5 dst_clk = ~dst_clk; // unrelated destination

    toggle_event_xfer #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_send(src_send),
        .src_data(src_data), .src_busy(src_busy),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_valid(dst_valid), .dst_data(dst_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge dst_clk) begin
        if (run_on) begin
            if (dst_valid) begin
                delivered++;
                check(!prev_valid, "R4 pulse width", 2, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected event", 1, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(dst_data == e, "R5 data/order", int'(dst_data), int'(e));
                    last_word = e;
                end
            end else begin
                check(dst_data == last_word, "R8 hold", int'(dst_data), int'(last_word));
            end
            prev_valid = dst_valid;
        end
    end

    task automatic send_evt(input logic [DATA_W-1:0] v, input bit poke);
        int lat;
        while (src_busy) @(negedge src_clk);
        src_send = 1'b1;
        src_data = v;
        @(negedge src_clk);
        src_send = 1'b0;
        check(src_busy == 1'b1, "R2 accept", int'(src_busy), 1);
        exp_q.push_back(v);
        accepted++;
        lat = 1;
        if (poke) begin
            // R3 and R9: send a different word while busy
            src_send = 1'b1;
            src_data = ~v;
            @(negedge src_clk);
            src_send = 1'b0;
            lat++;
            check(src_busy == 1'b1, "R3 still busy", int'(src_busy), 1);
        end
        while (src_busy && lat < 60) begin
            @(negedge src_clk);
            lat++;
        end
        check(!src_busy && lat >= 3, "R6 busy window", lat, 3);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge src_clk);
        check(src_busy == 1'b0, "R1 busy", int'(src_busy), 0);
        check(dst_valid == 1'b0, "R1 valid", int'(dst_valid), 0);
        check(dst_data == '0, "R1 data", int'(dst_data), 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        run_on = 1'b1;
        repeat (4) @(negedge src_clk);

        // R7: a run of events flips each line in both directions
        send_evt(8'hA5, 1'b0);
        send_evt(8'h5A, 1'b1);
        send_evt(8'hFF, 1'b0);
        send_evt(8'h00, 1'b1);
        send_evt(8'h01, 1'b1);
        send_evt(8'h80, 1'b0);
        for (int i = 0; i < 10; i++) send_evt(8'(i * 37 + 3), i[0]);
        // A gap with changing data and no send
        for (int i = 0; i < 20; i++) begin
            src_data = 8'(i);
            @(negedge src_clk);
        end
        send_evt(8'h3C, 1'b1);

        repeat (40) @(negedge src_clk);
        check(exp_q.size() == 0, "R7 all delivered", exp_q.size(), 0);
        check(delivered == accepted, "R3 no extra events", delivered, accepted);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule